// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two data buses, called A and B, through a group of non-inverting bit channels. It can pass data from one bus to the other as it arrives, or it can hold data in a register and send that stored copy out later. The block has one or more sections, and each section has its own controls. Each section holds two capture registers. The A-side register samples the A bus. The B-side register samples the B bus. Each register loads on the rising edge of its own capture strobe.

An active-low enable and a direction bit decide which bus, if either, the section drives:
- While the enable is high the section is isolated. Neither bus is driven, but both registers can still capture.
- While the enable is low and the direction bit is low, the section drives the A bus. A per-direction source select chooses between live B data and the stored B register.
- While the enable is low and the direction bit is high, the section drives the B bus. A per-direction source select chooses between live A data and the stored A register.

Each bus is modelled as an input vector, an output vector and a per-bit output-enable vector. The bus can then be resolved to a tri-state pad or a mux at the chip level. The capture strobes are sampled on the block clock. A capture happens in the cycle where a strobe is seen high after having been low in the previous cycle. A register always captures the value actually present on its bus. When the section is driving that bus, this is the driven value.

Top module: `regxcvr_top`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears both capture registers of every section to zero and clears the strobe history.
- R2: The A-side register of a section loads the A bus value at a clock edge where that section's cap_ab is 1 and was 0 at the previous edge. At every other edge it holds its value.
- R3: The B-side register of a section loads the B bus value at a clock edge where that section's cap_ba is 1 and was 0 at the previous edge. At every other edge it holds its value.
- R4: Capture works whatever the state of oe_n and dir. In isolation, both registers of a section may load at the same edge.
- R5: While a section's oe_n is 1, all of its a_oe and b_oe bits are 0 and its a_out and b_out are zero.
- R6: While oe_n is 0 and dir is 0, all a_oe bits of the section are 1 and b_oe is 0. a_out equals b_in when sel_ba is 0 (live), and equals the stored B-side register when sel_ba is 1.
- R7: While oe_n is 0 and dir is 1, all b_oe bits of the section are 1 and a_oe is 0. b_out equals a_in when sel_ab is 0 (live), and equals the stored A-side register when sel_ab is 1.
- R8: In a section, the A bus and the B bus are never driven at the same time.
- R9: When a section drives a bus and that bus's own capture strobe rises, the register loads the driven output value, not the bus input vector.
- R10: Sections are independent. Section s uses bits [s*WIDTH +: WIDTH] of every bus vector and bit s of every control vector, and no section's controls affect another section's outputs or registers.
- R11: A strobe held high for several cycles causes exactly one capture, at its first high edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled and registers load on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | NSEC | Per-section active-low output enable |
| dir | input | NSEC | Per-section direction: 0 drives A from B, 1 drives B from A |
| sel_ab | input | NSEC | B-bus source: 0 live A input, 1 stored A-side register |
| sel_ba | input | NSEC | A-bus source: 0 live B input, 1 stored B-side register |
| cap_ab | input | NSEC | Capture strobe for the A-side register |
| cap_ba | input | NSEC | Capture strobe for the B-side register |
| a_in | input | NSEC*WIDTH | Value seen on the A bus by the block |
| a_out | output | NSEC*WIDTH | Value the block drives onto the A bus |
| a_oe | output | NSEC*WIDTH | Per-bit drive enable for the A bus |
| b_in | input | NSEC*WIDTH | Value seen on the B bus by the block |
| b_out | output | NSEC*WIDTH | Value the block drives onto the B bus |
| b_oe | output | NSEC*WIDTH | Per-bit drive enable for the B bus |

## Verification
The bench goes after the capture source when a bus is being driven. It holds different values on the driven output and the input vector, so a design that samples the input vector loads the wrong byte. It holds a strobe high for several cycles and changes the data in between, which exposes a level-sensitive capture that keeps reloading. It captures into both registers while isolated and reads each back through the stored path, which catches a register loading only when outputs are enabled. It also drives one section while isolating the other and after a local capture, which catches crossed slices or shared controls.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the registered transceiver.
// Assumes: nothing beyond IEEE 1800-2017.
package xcvr_pkg;

    // Source chosen for a driven bus.
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    // Decoded drive state of one section.
    typedef struct packed {
        logic drive_a;
        logic drive_b;
    } drive_t;

endpackage

// File: rtl/xcvr_edge_det.sv
`timescale 1ns/1ps
// Module: xcvr_edge_det
// Turns a level strobe sampled on clk into a one-cycle capture pulse on its
// rising edge. Assumes the strobe is synchronous to clk.
module xcvr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic pulse
);

    logic prev_q;

    // Remember the strobe level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= strobe;
    end

    // A pulse marks a low-to-high change of the strobe.
    always_comb begin
        pulse = strobe & ~prev_q;
    end

    // R11: a held strobe never yields pulses on consecutive edges.
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/xcvr_cap_reg.sv
`timescale 1ns/1ps
// Module: xcvr_cap_reg
// Storage register of one transfer direction. It loads when load is high and
// holds otherwise. Assumes load is a single-cycle pulse from the edge detector.
module xcvr_cap_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Clear on reset, load on a capture pulse, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    // R2/R3: a capture pulse stores the presented bus value.
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R2/R3: without a pulse the stored value does not move.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/xcvr_drive_ctl.sv
`timescale 1ns/1ps
// Module: xcvr_drive_ctl
// Decodes the active-low enable and the direction bit into drive flags for the
// two buses. Assumes the controls are steady around the clock edge.
module xcvr_drive_ctl
    import xcvr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   oe_n,
    input  logic   dir,
    output drive_t drv
);

    // Only an enabled section drives, and only toward one side.
    always_comb begin
        drv.drive_a = 1'b0;
        drv.drive_b = 1'b0;
        if (!oe_n) begin
            if (dir) drv.drive_b = 1'b1;
            else     drv.drive_a = 1'b1;
        end
    end

    // R5: isolation keeps both buses released.
    assert_isolate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!drv.drive_a && !drv.drive_b));

    // R8: the two drive flags are exclusive.
    assert_excl_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv.drive_a, drv.drive_b}));

endmodule

// File: rtl/xcvr_section.sv
`timescale 1ns/1ps
// Module: xcvr_section
// One independent group of WIDTH channels. It holds the two capture registers,
// the live/stored source muxes and the drive decode. Assumes all controls are
// synchronous to clk.
module xcvr_section
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic             cap_ab,
    input  logic             cap_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);

    drive_t           drv;
    logic             pulse_ab;
    logic             pulse_ba;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic [WIDTH-1:0] a_bus;
    logic [WIDTH-1:0] b_bus;
    src_sel_e         src_ab;
    src_sel_e         src_ba;

    xcvr_drive_ctl u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .oe_n  (oe_n),
        .dir   (dir),
        .drv   (drv)
    );

    xcvr_edge_det u_edge_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_ab),
        .pulse  (pulse_ab)
    );

    xcvr_edge_det u_edge_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_ba),
        .pulse  (pulse_ba)
    );

    xcvr_cap_reg #(.WIDTH(WIDTH)) u_reg_a (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pulse_ab),
        .d     (a_bus),
        .q     (a_q)
    );

    xcvr_cap_reg #(.WIDTH(WIDTH)) u_reg_b (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pulse_ba),
        .d     (b_bus),
        .q     (b_q)
    );

    // Map the raw select bits onto the source type.
    always_comb begin
        src_ab = src_sel_e'(sel_ab);
        src_ba = src_sel_e'(sel_ba);
    end

    // Per-channel muxes, drive enables and the resolved bus values.
    for (genvar i = 0; i < WIDTH; i++) begin : g_chan
        logic a_src;
        logic b_src;
        assign a_src    = (src_ba == SRC_STORED) ? b_q[i] : b_in[i];
        assign b_src    = (src_ab == SRC_STORED) ? a_q[i] : a_in[i];
        assign a_out[i] = drv.drive_a & a_src;
        assign b_out[i] = drv.drive_b & b_src;
        assign a_oe[i]  = drv.drive_a;
        assign b_oe[i]  = drv.drive_b;
        assign a_bus[i] = drv.drive_a ? a_out[i] : a_in[i];
        assign b_bus[i] = drv.drive_b ? b_out[i] : b_in[i];
    end

    // R8: no bit of A and of B is enabled at the same time.
    assert_one_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !((|a_oe) && (|b_oe)));

    // R5: an isolated section presents zero on both outputs.
    assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (a_out == '0 && b_out == '0 && a_oe == '0 && b_oe == '0));

    // R9: capturing a driven B bus stores what was driven on it.
    assert_self_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_ba && (&b_oe)) |=> (b_q == $past(b_out)));

endmodule

// File: rtl/regxcvr_top.sv
`timescale 1ns/1ps
// Module: regxcvr_top
// Top of the registered transceiver. It instantiates NSEC independent sections
// of WIDTH channels. Bus and control vectors are sliced per section.
// Assumes a single clock domain for strobes and controls.
module regxcvr_top #(
    parameter int NSEC  = 2,
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSEC-1:0]       oe_n,
    input  logic [NSEC-1:0]       dir,
    input  logic [NSEC-1:0]       sel_ab,
    input  logic [NSEC-1:0]       sel_ba,
    input  logic [NSEC-1:0]       cap_ab,
    input  logic [NSEC-1:0]       cap_ba,
    input  logic [NSEC*WIDTH-1:0] a_in,
    output logic [NSEC*WIDTH-1:0] a_out,
    output logic [NSEC*WIDTH-1:0] a_oe,
    input  logic [NSEC*WIDTH-1:0] b_in,
    output logic [NSEC*WIDTH-1:0] b_out,
    output logic [NSEC*WIDTH-1:0] b_oe
);

    localparam int BUS_W = NSEC * WIDTH;

    // One section per control bit; R10 slice mapping.
    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        xcvr_section #(.WIDTH(WIDTH)) u_sec (
            .clk    (clk),
            .rst_n  (rst_n),
            .oe_n   (oe_n[s]),
            .dir    (dir[s]),
            .sel_ab (sel_ab[s]),
            .sel_ba (sel_ba[s]),
            .cap_ab (cap_ab[s]),
            .cap_ba (cap_ba[s]),
            .a_in   (a_in[s*WIDTH +: WIDTH]),
            .a_out  (a_out[s*WIDTH +: WIDTH]),
            .a_oe   (a_oe[s*WIDTH +: WIDTH]),
            .b_in   (b_in[s*WIDTH +: WIDTH]),
            .b_out  (b_out[s*WIDTH +: WIDTH]),
            .b_oe   (b_oe[s*WIDTH +: WIDTH])
        );
    end

    // R8: across the whole block, no bit position is driven on both sides.
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_oe & b_oe) == {BUS_W{1'b0}}));

endmodule

// File: tb/regxcvr_top_tb.sv
`timescale 1ns/1ps
module regxcvr_top_tb;

    localparam int NSEC = 2;
    localparam int W    = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSEC-1:0] oe_n = '1, dir = '0, sel_ab = '0, sel_ba = '0;
    logic [NSEC-1:0] cap_ab = '0, cap_ba = '0;
    logic [NSEC*W-1:0] a_in = '0, b_in = '0;
    logic [NSEC*W-1:0] a_out, a_oe, b_out, b_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    regxcvr_top #(.NSEC(NSEC), .WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // Row: oe_n dir sel_ab sel_ba | a_in b_in | exp a_en b_en | exp a_out b_out
    typedef struct packed {
        logic       oe_n, dir, sab, sba;
        logic [7:0] a, b;
        logic       aen, ben;
        logic [7:0] ao, bo;
    } row_t;

    // Registers hold A=3C, B=A5 during the walk (section 0).
    localparam logic [37:0] ROWS [8] = '{
        {4'b1000, 8'h11, 8'h22, 2'b00, 8'h00, 8'h00},
        {4'b1110, 8'h11, 8'h22, 2'b00, 8'h00, 8'h00},
        {4'b0000, 8'h11, 8'h22, 2'b10, 8'h22, 8'h00},
        {4'b0001, 8'h11, 8'h22, 2'b10, 8'hA5, 8'h00},
        {4'b0100, 8'h11, 8'h22, 2'b01, 8'h00, 8'h11},
        {4'b0110, 8'h11, 8'h22, 2'b01, 8'h00, 8'h3C},
        {4'b0000, 8'hFF, 8'h81, 2'b10, 8'h81, 8'h00},
        {4'b0100, 8'h7E, 8'h81, 2'b01, 8'h00, 8'h7E}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One strobe pulse on the chosen sections.
    task automatic strobe(input logic [NSEC-1:0] ab, input logic [NSEC-1:0] ba);
        cap_ab = ab;
        cap_ba = ba;
        tick();
        cap_ab = '0;
        cap_ba = '0;
        tick();
    endtask

    // Show the stored A-side register of section s on b_out.
    task automatic peek_a(input int s, output logic [7:0] v);
        oe_n[s] = 1'b0; dir[s] = 1'b1; sel_ab[s] = 1'b1;
        #1 v = b_out[s*W +: W];
    endtask

    // Show the stored B-side register of section s on a_out.
    task automatic peek_b(input int s, output logic [7:0] v);
        oe_n[s] = 1'b0; dir[s] = 1'b0; sel_ba[s] = 1'b1;
        #1 v = a_out[s*W +: W];
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        row_t r;

        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;

        // R1: registers read back zero after reset.
        peek_a(0, v); chk("R1 sec0 A reg", {8'h0, v}, 16'h0000);
        peek_b(0, v); chk("R1 sec0 B reg", {8'h0, v}, 16'h0000);
        peek_a(1, v); chk("R1 sec1 A reg", {8'h0, v}, 16'h0000);
        peek_b(1, v); chk("R1 sec1 B reg", {8'h0, v}, 16'h0000);

        // R4: isolated, both registers in both sections load on one edge.
        @(negedge clk);
        oe_n = '1;
        a_in = {8'h5A, 8'h3C};
        b_in = {8'hC3, 8'hA5};
        strobe(2'b11, 2'b11);
        peek_a(1, v); chk("R4 sec1 A reg", {8'h0, v}, 16'h005A);
        peek_b(1, v); chk("R4 sec1 B reg", {8'h0, v}, 16'h00C3);

        // Table walk on section 0 with section 1 isolated (R5, R6, R7, R8, R10).
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            r = row_t'(ROWS[i]);
            oe_n = {1'b1, r.oe_n};
            dir = {1'b0, r.dir};
            sel_ab = {1'b0, r.sab};
            sel_ba = {1'b0, r.sba};
            a_in[7:0] = r.a;
            b_in[7:0] = r.b;
            #1;
            if (r.oe_n) begin
                chk("R5 enables", {a_oe[7:0], b_oe[7:0]}, 16'h0000);
                chk("R5 outputs", {a_out[7:0], b_out[7:0]}, 16'h0000);
            end else if (r.dir) begin
                chk("R7 enables", {a_oe[7:0], b_oe[7:0]}, {8'h00, {8{r.ben}}});
                chk("R7 b_out", {8'h0, b_out[7:0]}, {8'h0, r.bo});
            end else begin
                chk("R6 enables", {a_oe[7:0], b_oe[7:0]}, {{8{r.aen}}, 8'h00});
                chk("R6 a_out", {8'h0, a_out[7:0]}, {8'h0, r.ao});
            end
            chk("R8 exclusive", a_oe & b_oe, 16'h0000);
            chk("R10 sec1 quiet", {a_oe[15:8] | b_oe[15:8], a_out[15:8] | b_out[15:8]}, 16'h0000);
        end

        // R2: no strobe -> hold; then a strobe loads a new value.
        @(negedge clk);
        oe_n = '1;
        a_in[7:0] = 8'hE7;
        repeat (2) tick();
        peek_a(0, v); chk("R2 hold", {8'h0, v}, 16'h003C);
        @(negedge clk);
        oe_n = '1;
        a_in[7:0] = 8'h4D;
        strobe(2'b01, 2'b00);
        peek_a(0, v); chk("R2 load", {8'h0, v}, 16'h004D);

        // R11: a strobe held high captures only at its first edge.
        @(negedge clk);
        oe_n = '1;
        a_in[7:0] = 8'h61;
        cap_ab = 2'b01;
        tick();
        a_in[7:0] = 8'h62;
        repeat (3) tick();
        cap_ab = '0;
        tick();
        peek_a(0, v); chk("R11 single capture", {8'h0, v}, 16'h0061);

        // R3 and R10: capture B in section 1 only.
        @(negedge clk);
        oe_n = '1;
        b_in[15:8] = 8'h77;
        strobe(2'b00, 2'b10);
        peek_b(1, v); chk("R3 sec1 B load", {8'h0, v}, 16'h0077);
        peek_b(0, v); chk("R10 sec0 B untouched", {8'h0, v}, 16'h00A5);
        peek_a(1, v); chk("R10 sec1 A untouched", {8'h0, v}, 16'h005A);

        // R9: B driven with live A; a B capture stores the driven value.
        @(negedge clk);
        oe_n = 2'b11;
        oe_n[0] = 1'b0; dir[0] = 1'b1; sel_ab[0] = 1'b0;
        a_in[7:0] = 8'h96;
        b_in[7:0] = 8'h00;
        strobe(2'b00, 2'b01);
        peek_b(0, v); chk("R9 driven capture", {8'h0, v}, 16'h0096);

        // R1: a reset mid-run clears stored data again.
        @(negedge clk);
        oe_n = '1;
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        peek_a(0, v); chk("R1 re-reset A", {8'h0, v}, 16'h0000);
        peek_b(1, v); chk("R1 re-reset B", {8'h0, v}, 16'h0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule